// File: doc/BRIEF.md
# Column-serial Grøstl-256 permutation engine

This block computes the two 512-bit permutations of the Grøstl-256 hash, P and Q, over a state viewed as an 8x8 matrix of bytes. It is a compact iterative engine. The datapath is one 64-bit column wide, so it needs eight S-boxes and one column mixer. Each round takes eight cycles, and a full permutation takes 80 cycles. Padding, chaining and output truncation are handled by the surrounding logic.

The state sits in one memory of eight 64-bit words. Each byte lane of a word has its own address, and each word holds one column. The engine never moves bytes to perform the row rotation. Each lane instead reads at an address built from three parts: the column counter, a fixed per-row shift and a per-row offset that grows every round. Each result byte is written back, in the same cycle, to the address it was read from.

The surrounding logic loads the state column by column while the engine is idle. It then pulses start with the P/Q select and waits for the done pulse. It reads the result column by column through the unload port. The unload port always presents logical column order.

Top module: `grostl_perm`

## Requirements
- R1: After reset, busy_o and done_o are low.
- R2: A start_i pulse while idle raises busy_o on the next cycle. busy_o then stays high for exactly 80 cycles. When busy_o falls, done_o is high for exactly one cycle.
- R3: While busy_o is high, start_i, sel_q_i and ld_en_i are ignored. The run length and the result are unchanged.
- R4: While idle, ld_en_i writes ld_data_i as logical column ld_col_i. rd_data_o shows logical column rd_col_i. Byte r of a column word (bits 8r+7..8r) is matrix row r. A column that is loaded reads back unchanged, including after an earlier run.
- R5: With sel_q_i=0, the result is P. P has 10 rounds, and each round applies four steps in this order: round-constant add, byte substitution, row rotation, column mixing. The P constant is the round index 0..9, XORed into row 0, column 0.
- R6: With sel_q_i=1, the result is Q. The Q constant is 0xFF XOR the round index, XORed into row 7, column 0.
- R7: The row rotation moves row r left by r columns for r=0..6, and moves row 7 left by 7 columns.
- R8: Column mixing multiplies each column over GF(2^8), using the AES reduction polynomial 0x11B. The matrix is circulant, with first row 02 02 03 04 05 03 05 07, and each following row is the previous row rotated right by one.
- R9: Byte substitution is the AES S-box.
- R10: The result stays in the state after done_o. A new start_i permutes that stored result again, with no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a permutation (taken only when idle) |
| sel_q_i | input | 1 | 0 selects P, 1 selects Q; sampled with start_i |
| ld_en_i | input | 1 | Write one state column (taken only when idle) |
| ld_col_i | input | 3 | Logical column to write |
| ld_data_i | input | 64 | Column data, byte r is row r |
| rd_col_i | input | 3 | Logical column to read |
| rd_data_o | output | 64 | Column data for rd_col_i (valid when idle) |
| busy_o | output | 1 | Permutation in progress |
| done_o | output | 1 | One-cycle pulse when a permutation finishes |

## Verification
A wrong address offset or a wrong round constant does not stay contained. It corrupts every byte within a round or two through column mixing. The error therefore shows in all eight unloaded columns as soon as done_o rises, so each result is compared word by word against an independent matrix model. Sequencing faults show at the ports sooner: the busy_o length and the done_o pulse are measured cycle by cycle on every run. The load and unload checks run after earlier permutations, when the per-row offsets are non-zero. That exposes any mismatch between the logical and the physical column order.

// File: rtl/grostl_pkg.sv
package grostl_pkg;
  typedef logic [7:0] byte_t;

  function automatic byte_t xtime(byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gmul(byte_t a, byte_t b);
    byte_t p = '0;
    byte_t x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xtime(x);
    end
    return p;
  endfunction

  // a^254 is the multiplicative inverse; 0 maps to 0
  function automatic byte_t ginv(byte_t a);
    byte_t r = 8'h01;
    byte_t s = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gmul(r, s);
      s = gmul(s, s);
    end
    return r;
  endfunction

  function automatic byte_t sbox_f(byte_t a);
    byte_t v;
    v = ginv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
             ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  function automatic byte_t mix_coef(int k);
    case (k)
      0, 1:    return 8'h02;
      2:       return 8'h03;
      3:       return 8'h04;
      4:       return 8'h05;
      5:       return 8'h03;
      6:       return 8'h05;
      default: return 8'h07;
    endcase
  endfunction

  function automatic int row_shift(int r, int nr);
    return (r == nr - 1) ? 7 : r;
  endfunction
endpackage

// File: rtl/grostl_sbox.sv
module grostl_sbox
  import grostl_pkg::*;
(
  input  logic [7:0] a_i,
  output logic [7:0] y_o
);
  assign y_o = sbox_f(a_i);
endmodule

// File: rtl/grostl_mix_col.sv
module grostl_mix_col
  import grostl_pkg::*;
#(
  parameter int NR = 8
) (
  input  logic [NR*8-1:0] col_i,
  output logic [NR*8-1:0] col_o
);
  for (genvar i = 0; i < NR; i++) begin : g_out
    byte_t acc;
    always_comb begin
      acc = '0;
      for (int j = 0; j < NR; j++)
        acc = acc ^ gmul(mix_coef((j - i + NR) % NR), col_i[8*j +: 8]);
    end
    assign col_o[8*i +: 8] = acc;
  end
endmodule

// File: rtl/grostl_state_mem.sv
module grostl_state_mem #(
  parameter int NR    = 8,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic                   clk_i,
  input  logic                   we_i,
  input  logic [NR-1:0][AW-1:0]  waddr_i,
  input  logic [NR-1:0][AW-1:0]  raddr_i,
  input  logic [NR*8-1:0]        wdata_i,
  output logic [NR*8-1:0]        rdata_o
);
  // one byte lane per row, each with its own address
  for (genvar r = 0; r < NR; r++) begin : g_lane
    logic [7:0] lane_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i) lane_q[waddr_i[r]] <= wdata_i[8*r +: 8];
    end
    assign rdata_o[8*r +: 8] = lane_q[raddr_i[r]];
  end
endmodule

// File: rtl/grostl_ctrl.sv
module grostl_ctrl
  import grostl_pkg::*;
#(
  parameter int NR     = 8,
  parameter int NC     = 8,
  parameter int AW     = 3,
  parameter int ROUNDS = 10,
  parameter int RCW    = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  sel_q_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  sel_q_o,
  output logic [AW-1:0]         sub_o,
  output logic [RCW-1:0]        round_o,
  output logic [NR-1:0][AW-1:0] base_o
);
  logic                  busy_q, done_q, sel_q;
  logic [AW-1:0]         sub_q;
  logic [RCW-1:0]        round_q;
  logic [NR-1:0][AW-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      sel_q   <= 1'b0;
      sub_q   <= '0;
      round_q <= '0;
      base_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          sel_q   <= sel_q_i;
          sub_q   <= '0;
          round_q <= '0;
        end
      end else begin
        sub_q <= sub_q + 1'b1;
        if (sub_q == AW'(NC - 1)) begin
          round_q <= round_q + 1'b1;
          // offsets accumulate each round's rotation (mod NC)
          for (int r = 0; r < NR; r++)
            base_q[r] <= base_q[r] + AW'(row_shift(r, NR));
          if (round_q == RCW'(ROUNDS - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign sel_q_o = sel_q;
  assign sub_o   = sub_q;
  assign round_o = round_q;
  assign base_o  = base_q;
endmodule

// File: rtl/grostl_perm.sv
module grostl_perm
  import grostl_pkg::*;
#(
  parameter int  NR     = 8,
  parameter int  NC     = 8,
  parameter int  ROUNDS = 10,
  localparam int AW     = $clog2(NC),
  localparam int W      = NR * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          sel_q_i,
  input  logic          ld_en_i,
  input  logic [AW-1:0] ld_col_i,
  input  logic [W-1:0]  ld_data_i,
  input  logic [AW-1:0] rd_col_i,
  output logic [W-1:0]  rd_data_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int RCW = $clog2(ROUNDS + 1);

  logic                  busy, sel_q;
  logic [AW-1:0]         sub;
  logic [RCW-1:0]        round;
  logic [NR-1:0][AW-1:0] base, waddr, raddr;
  logic [W-1:0]          rdata, sb_col, mix_col, wdata;
  byte_t                 rnd_b;

  grostl_ctrl #(.NR(NR), .NC(NC), .AW(AW), .ROUNDS(ROUNDS), .RCW(RCW)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .sel_q_i (sel_q_i),
    .busy_o  (busy),
    .done_o  (done_o),
    .sel_q_o (sel_q),
    .sub_o   (sub),
    .round_o (round),
    .base_o  (base)
  );

  assign rnd_b = 8'(round);

  for (genvar r = 0; r < NR; r++) begin : g_row
    logic [AW-1:0] lcol, caddr;
    byte_t         cst, arc;
    // logical column read by this lane = sub + row rotation
    assign lcol  = sub + AW'(row_shift(r, NR));
    assign caddr = lcol + base[r];
    assign waddr[r] = busy ? caddr : ld_col_i + base[r];
    assign raddr[r] = busy ? caddr : rd_col_i + base[r];

    if (r == 0) begin : g_pc
      assign cst = (!sel_q && lcol == '0) ? rnd_b : 8'h00;
    end else if (r == NR - 1) begin : g_qc
      assign cst = (sel_q && lcol == '0) ? (8'hff ^ rnd_b) : 8'h00;
    end else begin : g_nc
      assign cst = 8'h00;
    end

    assign arc = rdata[8*r +: 8] ^ cst;

    grostl_sbox u_sbox (
      .a_i (arc),
      .y_o (sb_col[8*r +: 8])
    );
  end

  grostl_mix_col #(.NR(NR)) u_mix (
    .col_i (sb_col),
    .col_o (mix_col)
  );

  assign wdata = busy ? mix_col : ld_data_i;

  grostl_state_mem #(.NR(NR), .DEPTH(NC), .AW(AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (busy | ld_en_i),
    .waddr_i (waddr),
    .raddr_i (raddr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  assign rd_data_o = rdata;
  assign busy_o    = busy;
endmodule

// File: rtl/grostl_perm_chk.sv
module grostl_perm_chk #(
  parameter int LAT = 80
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o
);
  logic [15:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_cnt <= '0;
    else if (!busy_o) busy_cnt <= '0;
    else              busy_cnt <= busy_cnt + 1'b1;
  end

  // R1
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R2
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  done_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R3
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_cnt == 16'(LAT)));
endmodule

bind grostl_perm grostl_perm_chk #(.LAT(ROUNDS * NC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/sim_grostl_perm.sv
module sim_grostl_perm;
  localparam int CLK_PERIOD = 10;
  typedef logic [7:0] b8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, sel_q_i = 1'b0, ld_en_i = 1'b0;
  logic [2:0]  ld_col_i = '0, rd_col_i = '0;
  logic [63:0] ld_data_i = '0;
  logic [63:0] rd_data_o;
  logic        busy_o, done_o;

  int checks = 0;
  int errs   = 0;

  b8 sb [256];
  b8 ms [8][8];
  b8 cf [8] = '{8'h02, 8'h02, 8'h03, 8'h04, 8'h05, 8'h03, 8'h05, 8'h07};

  always #(CLK_PERIOD / 2) clk = ~clk;

  grostl_perm u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .sel_q_i(sel_q_i),
    .ld_en_i(ld_en_i), .ld_col_i(ld_col_i), .ld_data_i(ld_data_i),
    .rd_col_i(rd_col_i), .rd_data_o(rd_data_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic b8 bm(b8 a, b8 b);
    b8 r = '0;
    for (int i = 7; i >= 0; i--) begin
      r = {r[6:0], 1'b0} ^ (r[7] ? 8'h1b : 8'h00);
      if (a[i]) r = r ^ b;
    end
    return r;
  endfunction

  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      b8 v = '0;
      b8 s;
      if (x != 0)
        for (int y = 1; y < 256; y++)
          if (bm(b8'(x), b8'(y)) == 8'h01) v = b8'(y);
      for (int i = 0; i < 8; i++)
        s[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ b8'(8'h63 >> i);
      sb[x] = s;
    end
  endtask

  task automatic model_run(input bit q);
    b8 t [8][8];
    for (int rd = 0; rd < 10; rd++) begin
      if (q) ms[7][0] = ms[7][0] ^ (8'hff ^ b8'(rd));
      else   ms[0][0] = ms[0][0] ^ b8'(rd);
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 8; c++)
          t[r][c] = sb[ms[r][(c + ((r == 7) ? 7 : r)) % 8]];
      for (int i = 0; i < 8; i++)
        for (int c = 0; c < 8; c++) begin
          b8 acc = '0;
          for (int j = 0; j < 8; j++) acc = acc ^ bm(cf[(j - i + 8) % 8], t[j][c]);
          ms[i][c] = acc;
        end
    end
  endtask

  function automatic logic [63:0] col_word(int c);
    logic [63:0] w;
    for (int r = 0; r < 8; r++) w[8*r +: 8] = ms[r][c];
    return w;
  endfunction

  function automatic b8 pat(int p, int r, int c);
    case (p)
      0: return 8'h00;
      1: return b8'(r * 8 + c);
      2: return 8'hff;
      default: return b8'(r * 37 + c * 101 + 13);
    endcase
  endfunction

  task automatic load_model();
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      ld_en_i = 1'b1; ld_col_i = 3'(c); ld_data_i = col_word(c);
    end
    @(negedge clk);
    ld_en_i = 1'b0;
  endtask

  task automatic compare(input string tag);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      rd_col_i = 3'(c);
      #1;
      chk(rd_data_o === col_word(c), tag, rd_data_o, col_word(c));
    end
  endtask

  task automatic run(input bit q, input bit disturb);
    int n = 0;
    @(negedge clk);
    start_i = 1'b1; sel_q_i = q;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R2 busy after start", 64'(busy_o), 64'd1);
    while (busy_o === 1'b1 && n < 200) begin
      if (disturb && n == 20) begin
        ld_en_i = 1'b1; ld_col_i = 3'd3; ld_data_i = '1; start_i = 1'b1; sel_q_i = !q;
      end else begin
        ld_en_i = 1'b0; start_i = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    ld_en_i = 1'b0; start_i = 1'b0;
    chk(n == 80, disturb ? "R3 run length with disturbance" : "R2 run length", 64'(n), 64'd80);
    chk(done_o === 1'b1, "R2 done at end", 64'(done_o), 64'd1);
    @(negedge clk);
    chk(done_o === 1'b0, "R2 done one cycle", 64'(done_o), 64'd0);
    chk(busy_o === 1'b0, "R2 idle after done", 64'(busy_o), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    build_sbox();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(busy_o === 1'b0, "R1 busy after reset", 64'(busy_o), 64'd0);
    chk(done_o === 1'b0, "R1 done after reset", 64'(done_o), 64'd0);

    // R4 roundtrip with zero offsets
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) ms[r][c] = pat(1, r, c);
    load_model();
    compare("R4 roundtrip fresh");

    // R5 R6 R7 R8 R9 over patterns and both permutations
    for (int p = 0; p < 4; p++)
      for (int q = 0; q < 2; q++) begin
        for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) ms[r][c] = pat(p, r, c);
        load_model();
        compare("R4 roundtrip after runs");
        run(q[0], 1'b0);
        model_run(q[0]);
        compare(q ? "R6 R7 R8 R9 Q result" : "R5 R7 R8 R9 P result");
      end

    // R10 chained runs without reload
    run(1'b0, 1'b0);
    model_run(1'b0);
    compare("R10 chained P");
    run(1'b1, 1'b0);
    model_run(1'b1);
    compare("R10 chained Q");

    // R3 start/select/load ignored while busy
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) ms[r][c] = pat(3, r, c);
    load_model();
    run(1'b0, 1'b1);
    model_run(1'b0);
    compare("R3 result unaffected by inputs while busy");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule